// File: doc/BRIEF.md
# Regulator Start-Up and Protection Sequencer

This block sits beside the switching controller of an off-line regulator and decides, every clock, whether the power switch may run. It watches four digitised inputs: the supply-rail code, the die-temperature code, the output of the mains brownout comparator and a flag saying the internal reference is valid. From these it drives the enable of the high-voltage start-up current source, a gate pull-down that holds the power switch off, the PWM enable, a one-cycle reset pulse for the rest of the control logic, and the enable of the current source that gives the brownout comparator its hysteresis.

The sequencer has three states. It starts in lockout, moves through a one-cycle reset phase, and then runs. The supply uses two thresholds: a high start level and a lower drop-out level. An overvoltage event is held until the rail sags below the drop-out level. A thermal event clears itself once the temperature has fallen back by a set margin. A brownout only gates the PWM. A 3-bit cause code reports which condition is holding switching off, by a fixed priority. All thresholds are parameters.

Top module: `supply_supervisor`

## Requirements
- R1: After reset, startup_en=1, gate_pulldown=1, pwm_en=0, logic_rst=0, bo_hyst_en=0 and fault_cause=1.
- R2: While not running (lockout or the reset phase), startup_en=1, gate_pulldown=1 and pwm_en=0.
- R3: In lockout, a sampled vcc_code >= START_TH with ref_ok=1 moves the block to the reset phase on the next cycle, with logic_rst=1 for exactly one cycle. If no stop condition is present it then runs, with startup_en=0 and gate_pulldown=0. Otherwise it returns to lockout.
- R4: While running, a sampled vcc_code < LOCK_TH returns the block to lockout on the next cycle. In lockout, a code between LOCK_TH and START_TH-1 keeps it in lockout.
- R5: While running, a sampled vcc_code > OVP_TH sets an overvoltage hold (fault_cause=2, pwm_en=0) from the next cycle. The hold persists at any code >= LOCK_TH and is cleared only by a stop that returns the block to lockout.
- R6: A temperature code >= TEMP_TRIP sets an over-temperature flag. The flag clears only at a code <= TEMP_TRIP-TEMP_HYST, with no latching. While it is set in the running state, pwm_en=0, fault_cause=3 and startup_en stays 0.
- R7: bo_hyst_en equals bo_above as sampled one cycle earlier. A low sample gives pwm_en=0 and fault_cause=4 when nothing of higher rank is active.
- R8: ref_ok=0 acts as a stop: the block goes to lockout on the next cycle and cannot leave it while ref_ok=0.
- R9: fault_cause reports the highest-ranked condition: 1 not running, then 2 overvoltage hold, then 3 over-temperature, then 4 brownout; otherwise 0.
- R10: pwm_en=1 exactly when the block is running and fault_cause=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vcc_code | input | VW | Digitised supply-rail level |
| temp_code | input | TW | Digitised die temperature |
| bo_above | input | 1 | Brownout comparator: 1 when mains sense is above its reference |
| ref_ok | input | 1 | Internal reference within range |
| pwm_en | output | 1 | Switching permitted |
| startup_en | output | 1 | High-voltage start-up source on |
| gate_pulldown | output | 1 | Power-switch gate clamped low |
| logic_rst | output | 1 | One-cycle reset to the control logic on each start |
| bo_hyst_en | output | 1 | Brownout hysteresis current source on |
| fault_cause | output | 3 | Active stop cause (0 none, 1 lockout, 2 overvoltage, 3 thermal, 4 brownout) |

## Verification
The supply code is ramped slowly through the band between the two thresholds. This separates a correct two-level lockout from a single-level comparison in both directions. An overvoltage spike is followed by a sag that stays above drop-out, then by a sag that goes below it. Only a true hold stays set through the first sag and clears on the second. The temperature is walked into the band between trip and release, and several faults are stacked so that the cause code shows the ranking. Further patterns cover a reference drop, a restart while hot, and a drop during the reset phase.

// File: rtl/supsv_pkg.sv
package supsv_pkg;

    typedef enum logic [1:0] {
        ST_LOCKOUT  = 2'd0,
        ST_STARTING = 2'd1,
        ST_RUN      = 2'd2
    } sup_state_t;

    typedef enum logic [2:0] {
        CAUSE_NONE     = 3'd0,
        CAUSE_LOCKOUT  = 3'd1,
        CAUSE_OVP      = 3'd2,
        CAUSE_THERMAL  = 3'd3,
        CAUSE_BROWNOUT = 3'd4
    } cause_t;

    typedef struct packed {
        logic ovp_hold;
        logic over_temp;
        logic bo_low;
    } fault_flags_t;

    // Ranking of stop causes; the lowest code that applies wins.
    function automatic cause_t rank_cause(input logic running, input fault_flags_t f);
        if (!running)        return CAUSE_LOCKOUT;
        else if (f.ovp_hold) return CAUSE_OVP;
        else if (f.over_temp) return CAUSE_THERMAL;
        else if (f.bo_low)   return CAUSE_BROWNOUT;
        else                 return CAUSE_NONE;
    endfunction

endpackage

// File: rtl/supsv_sequencer.sv
module supsv_sequencer
    import supsv_pkg::*;
#(
    parameter int VW       = 8,
    parameter int START_TH = 145,
    parameter int LOCK_TH  = 100
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [VW-1:0]    vcc_code,
    input  logic             ref_ok,
    output sup_state_t       state,
    output logic             lock_req
);
    localparam logic [VW-1:0] START_CODE = VW'(START_TH);
    localparam logic [VW-1:0] LOCK_CODE  = VW'(LOCK_TH);

    logic       start_ok;
    sup_state_t state_nx;

    always_comb begin
        lock_req = (vcc_code < LOCK_CODE) || !ref_ok;
        start_ok = (vcc_code >= START_CODE) && ref_ok;
        state_nx = state;
        unique case (state)
            ST_LOCKOUT:  state_nx = start_ok ? ST_STARTING : ST_LOCKOUT;
            ST_STARTING: state_nx = lock_req ? ST_LOCKOUT : ST_RUN;
            ST_RUN:      state_nx = lock_req ? ST_LOCKOUT : ST_RUN;
            default:     state_nx = ST_LOCKOUT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_LOCKOUT;
        else     state <= state_nx;
    end
endmodule

// File: rtl/supsv_ovp_latch.sv
module supsv_ovp_latch #(
    parameter int VW     = 8,
    parameter int OVP_TH = 180
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [VW-1:0] vcc_code,
    input  logic          running,
    input  logic          lock_req,
    output logic          ovp_hold
);
    localparam logic [VW-1:0] OVP_CODE = VW'(OVP_TH);

    always_ff @(posedge clk) begin
        if (rst || lock_req)
            ovp_hold <= 1'b0;
        else if (running && (vcc_code > OVP_CODE))
            ovp_hold <= 1'b1;
    end
endmodule

// File: rtl/supsv_thermal.sv
module supsv_thermal #(
    parameter int TW        = 8,
    parameter int TEMP_TRIP = 150,
    parameter int TEMP_HYST = 40
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [TW-1:0] temp_code,
    output logic          over_temp
);
    localparam int              CLR_LVL   = TEMP_TRIP - TEMP_HYST;
    localparam logic [TW-1:0]   TRIP_CODE = TW'(TEMP_TRIP);
    localparam logic [TW-1:0]   CLR_CODE  = TW'(CLR_LVL);

    always_ff @(posedge clk) begin
        if (rst)
            over_temp <= 1'b0;
        else if (temp_code >= TRIP_CODE)
            over_temp <= 1'b1;
        else if (temp_code <= CLR_CODE)
            over_temp <= 1'b0;
    end
endmodule

// File: rtl/supsv_brownout.sv
module supsv_brownout (
    input  logic clk,
    input  logic rst,
    input  logic bo_above,
    output logic bo_ok
);
    always_ff @(posedge clk) begin
        if (rst) bo_ok <= 1'b0;
        else     bo_ok <= bo_above;
    end
endmodule

// File: rtl/supply_supervisor.sv
module supply_supervisor
    import supsv_pkg::*;
#(
    parameter int VW        = 8,
    parameter int TW        = 8,
    parameter int START_TH  = 145,
    parameter int LOCK_TH   = 100,
    parameter int OVP_TH    = 180,
    parameter int TEMP_TRIP = 150,
    parameter int TEMP_HYST = 40
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [VW-1:0] vcc_code,
    input  logic [TW-1:0] temp_code,
    input  logic          bo_above,
    input  logic          ref_ok,
    output logic          pwm_en,
    output logic          startup_en,
    output logic          gate_pulldown,
    output logic          logic_rst,
    output logic          bo_hyst_en,
    output logic [2:0]    fault_cause
);
    sup_state_t   state;
    logic         lock_req;
    logic         running;
    logic         bo_ok;
    fault_flags_t flags;
    cause_t       cause;

    assign running = (state == ST_RUN);

    supsv_sequencer #(.VW(VW), .START_TH(START_TH), .LOCK_TH(LOCK_TH)) u_seq (
        .clk(clk), .rst(rst), .vcc_code(vcc_code), .ref_ok(ref_ok),
        .state(state), .lock_req(lock_req)
    );

    supsv_ovp_latch #(.VW(VW), .OVP_TH(OVP_TH)) u_ovp (
        .clk(clk), .rst(rst), .vcc_code(vcc_code), .running(running),
        .lock_req(lock_req), .ovp_hold(flags.ovp_hold)
    );

    supsv_thermal #(.TW(TW), .TEMP_TRIP(TEMP_TRIP), .TEMP_HYST(TEMP_HYST)) u_therm (
        .clk(clk), .rst(rst), .temp_code(temp_code), .over_temp(flags.over_temp)
    );

    supsv_brownout u_bo (
        .clk(clk), .rst(rst), .bo_above(bo_above), .bo_ok(bo_ok)
    );

    assign flags.bo_low = !bo_ok;

    always_comb begin
        cause         = rank_cause(running, flags);
        fault_cause   = cause;
        pwm_en        = (cause == CAUSE_NONE);
        startup_en    = !running;
        gate_pulldown = !running;
        logic_rst     = (state == ST_STARTING);
        bo_hyst_en    = bo_ok;
    end
endmodule

// File: rtl/supsv_checker.sv
module supsv_checker #(
    parameter int VW      = 8,
    parameter int LOCK_TH = 100
) (
    input logic          clk,
    input logic          rst,
    input logic [VW-1:0] vcc_code,
    input logic          bo_above,
    input logic          ref_ok,
    input logic          pwm_en,
    input logic          startup_en,
    input logic          gate_pulldown,
    input logic          logic_rst,
    input logic          bo_hyst_en,
    input logic [2:0]    fault_cause
);
    localparam logic [VW-1:0] LOCK_CODE = VW'(LOCK_TH);

    a_r2_lockout_outputs: assert property (@(posedge clk) disable iff (rst)
        (fault_cause == 3'd1) |-> (startup_en && gate_pulldown && !pwm_en));

    a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
        logic_rst |=> !logic_rst);

    a_r3_reset_before_run: assert property (@(posedge clk) disable iff (rst)
        $fell(startup_en) |-> $past(logic_rst));

    a_r4_drop_to_lockout: assert property (@(posedge clk) disable iff (rst)
        (!startup_en && (vcc_code < LOCK_CODE)) |=> startup_en);

    a_r5_ovp_hold: assert property (@(posedge clk) disable iff (rst)
        ((fault_cause == 3'd2) && (vcc_code >= LOCK_CODE) && ref_ok) |=> (fault_cause == 3'd2));

    a_r7_hyst_follows: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (bo_hyst_en == $past(bo_above)));

    a_r8_ref_loss: assert property (@(posedge clk) disable iff (rst)
        !ref_ok |=> startup_en);

    a_r10_pwm_clean: assert property (@(posedge clk) disable iff (rst)
        pwm_en |-> (fault_cause == 3'd0));
endmodule

bind supply_supervisor supsv_checker #(.VW(VW), .LOCK_TH(LOCK_TH)) u_chk (
    .clk(clk), .rst(rst), .vcc_code(vcc_code), .bo_above(bo_above), .ref_ok(ref_ok),
    .pwm_en(pwm_en), .startup_en(startup_en), .gate_pulldown(gate_pulldown),
    .logic_rst(logic_rst), .bo_hyst_en(bo_hyst_en), .fault_cause(fault_cause)
);

// File: tb/supply_supervisor_test.sv
module supply_supervisor_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] vcc_code = 8'd0;
    logic [7:0] temp_code = 8'd25;
    logic       bo_above = 1'b1;
    logic       ref_ok = 1'b1;
    logic       pwm_en, startup_en, gate_pulldown, logic_rst, bo_hyst_en;
    logic [2:0] fault_cause;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    // Behavioural reference: 0 lockout, 1 reset phase, 2 running
    int m_st  = 0;
    bit m_ovp = 0, m_hot = 0, m_bo = 0;

    always #2 clk = ~clk;

    supply_supervisor uut (
        .clk(clk), .rst(rst), .vcc_code(vcc_code), .temp_code(temp_code),
        .bo_above(bo_above), .ref_ok(ref_ok), .pwm_en(pwm_en),
        .startup_en(startup_en), .gate_pulldown(gate_pulldown),
        .logic_rst(logic_rst), .bo_hyst_en(bo_hyst_en), .fault_cause(fault_cause)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_ovp = 0; m_hot = 0; m_bo = 0;
        end else begin
            bit stop;
            stop = (vcc_code < 100) || !ref_ok;
            if (stop) m_ovp = 0;
            else if (m_st == 2 && vcc_code > 180) m_ovp = 1;
            if (temp_code >= 150) m_hot = 1;
            else if (temp_code <= 110) m_hot = 0;
            m_bo = bo_above;
            case (m_st)
                0: if (vcc_code >= 145 && ref_ok) m_st = 1;
                default: m_st = stop ? 0 : 2;
            endcase
        end
    end

    function automatic int exp_cause();
        if (m_st != 2) return 1;
        if (m_ovp) return 2;
        if (m_hot) return 3;
        if (!m_bo) return 4;
        return 0;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
        end
    endtask

    // Per-cycle comparison against the reference model
    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R9 cause", int'(fault_cause), exp_cause());
            check("R10 pwm", int'(pwm_en), (exp_cause() == 0) ? 1 : 0);
            check("R2 startup", int'(startup_en), (m_st != 2) ? 1 : 0);
            check("R2 pulldown", int'(gate_pulldown), (m_st != 2) ? 1 : 0);
            check("R3 logic_rst", int'(logic_rst), (m_st == 1) ? 1 : 0);
            check("R7 hyst", int'(bo_hyst_en), int'(m_bo));
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        tick(3);
        rst = 1'b0;
        tick(1);
        // R1 reset state (bo_hyst_en not yet sampled high at this point? sampled once)
        check("R1 startup", int'(startup_en), 1);
        check("R1 pulldown", int'(gate_pulldown), 1);
        check("R1 cause", int'(fault_cause), 1);
        check("R1 pwm", int'(pwm_en), 0);

        // R4 slow ramp through the hysteresis band
        for (int v = 0; v <= 140; v += 10) begin
            vcc_code = 8'(v);
            tick(1);
            check("R4 lockout during ramp", int'(startup_en), 1);
        end
        vcc_code = 8'd150; tick(1);
        check("R3 pulse", int'(logic_rst), 1);
        check("R3 still clamped", int'(gate_pulldown), 1);
        tick(1);
        check("R3 pulse ends", int'(logic_rst), 0);
        check("R3 startup off", int'(startup_en), 0);
        check("R10 pwm on", int'(pwm_en), 1);

        vcc_code = 8'd120; tick(1);
        check("R4 stays running in band", int'(startup_en), 0);

        // R7 brownout
        bo_above = 1'b0; tick(1);
        check("R7 cause", int'(fault_cause), 4);
        check("R7 hyst off", int'(bo_hyst_en), 0);
        bo_above = 1'b1; tick(1);
        check("R7 recover", int'(pwm_en), 1);

        // R6 thermal walk
        temp_code = 8'd150; tick(1);
        check("R6 trip", int'(fault_cause), 3);
        check("R6 startup stays off", int'(startup_en), 0);
        temp_code = 8'd115; tick(1);
        check("R6 still hot in band", int'(fault_cause), 3);
        temp_code = 8'd110; tick(1);
        check("R6 release", int'(fault_cause), 0);

        // R9 stacked faults
        temp_code = 8'd160; bo_above = 1'b0; tick(1);
        check("R9 thermal over brownout", int'(fault_cause), 3);
        temp_code = 8'd25; bo_above = 1'b1; tick(1);

        // R5 overvoltage hold
        vcc_code = 8'd190; tick(1);
        check("R5 trip", int'(fault_cause), 2);
        vcc_code = 8'd130; tick(1);
        check("R5 held after sag", int'(fault_cause), 2);
        temp_code = 8'd160; tick(1);
        check("R9 ovp over thermal", int'(fault_cause), 2);
        temp_code = 8'd25; tick(2);
        vcc_code = 8'd90; tick(1);
        check("R5 cleared into lockout", int'(fault_cause), 1);
        vcc_code = 8'd130; tick(1);
        check("R4 band keeps lockout", int'(startup_en), 1);
        vcc_code = 8'd150; tick(2);
        check("R5 hold gone after restart", int'(fault_cause), 0);

        // R8 reference loss
        ref_ok = 1'b0; tick(1);
        check("R8 lockout", int'(fault_cause), 1);
        tick(2);
        check("R8 stays locked", int'(startup_en), 1);
        ref_ok = 1'b1; tick(2);
        check("R8 restart", int'(pwm_en), 1);

        // R6 restart while hot: supply cycles, switching stays off
        temp_code = 8'd160; tick(1);
        vcc_code = 8'd90; tick(1);
        check("R6 lockout while hot", int'(startup_en), 1);
        vcc_code = 8'd150; tick(2);
        check("R6 hot after restart", int'(fault_cause), 3);
        temp_code = 8'd25; tick(1);
        check("R6 resume", int'(pwm_en), 1);

        // R3 stop during the reset phase
        vcc_code = 8'd90; tick(1);
        vcc_code = 8'd150; tick(1);
        check("R3 reset phase", int'(logic_rst), 1);
        vcc_code = 8'd90; tick(1);
        check("R3 abort to lockout", int'(startup_en), 1);
        tick(2);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule